// File: doc/BRIEF.md
# Hot-Plug Register Script Sequencer

This block runs one single-byte read or write to a hot-plug controller that sits behind a memory-mapped I2C master. It does not drive the I2C wires. Instead it plays a fixed script of 32-bit register accesses on a simple valid/ready host bus:

- a setup word at offset 0x10;
- a message-buffer word at 0x08;
- a start request to the control register 0x20, made through its bit-set alias at 0x2020;
- a bounded poll of the control register until the start bit drops;
- a bounded poll of the status register at 0x70;
- for reads, one fetch of the message buffer.

Every word crosses the bus byte-reversed in both directions.

A request carries these fields: direction, addressing mode, an 8-bit device address byte (bits 7:1 are used), an 8-bit register index and a write byte. The block accepts one request while it is idle. It ends every request with a one-cycle `done` pulse, with `err` valid alongside it. `rdata` holds the fetched byte after a read that completes without error. The spacing between polls comes from the `poll_gap` input, counted in clock cycles.

The control machine has ten states, entered in this order:

- IDLE: waits for a request.
- SETUP, MBUF, START: the three writes.
- GAP_CTRL and POLL_CTRL: the start-bit loop.
- GAP_STAT and POLL_STAT: the status loop.
- FETCH: the read-back.
- DONE: the completion pulse.

The transitions are:

- IDLE→SETUP when a request with a supported mode is accepted. IDLE→DONE when the mode is unsupported.
- SETUP→MBUF→START→GAP_CTRL, each on a bus handshake.
- GAP→POLL when the gap counter expires.
- POLL_CTRL→GAP_CTRL on a failed poll, and POLL_CTRL→GAP_STAT when the start bit is clear.
- POLL_CTRL→DONE on a start timeout during a read. POLL_CTRL→GAP_STAT on a start timeout during a write.
- POLL_STAT→GAP_STAT on a failed poll.
- POLL_STAT→FETCH on a clear status during a read. POLL_STAT→DONE on a clear status during a write, or on a status timeout.
- FETCH→DONE, then DONE→IDLE.

Top module: `hp_i2c_seq`

## Requirements
- R1: A supported request makes exactly this access order: write 0x10, write 0x08, write 0x2020, one or more reads of 0x20, one or more reads of 0x70, and for a clean read one read of 0x08. Each access holds valid, address, direction and data stable until ready.
- R2: In addressed mode (req_mode 2'b00) the setup word is 0x00010000 for a read or 0x40010000 for a write, ORed with device address bits 7:1 in bits 14:8 and the index in bits 7:0.
- R3: In direct mode (req_mode 2'b01) the setup word is 0x10010000 for a read or 0x60010000 for a write, ORed with the index in bits 15:8.
- R4: The message-buffer word is zero for a read and {24'h0, write byte} for a write.
- R5: The start request writes the value 0x00000002 to address 0x2020, which is the control offset plus the bit-set alias 0x2000.
- R6: Each word is byte-reversed on the bus. Written data has its bytes swapped, and read data is swapped before any test is applied.
- R7: A status poll counts as complete when the swapped status word ANDed with 0x00000A76 is zero. Bits outside that mask are ignored.
- R8: The start-bit loop makes at most 60 reads of 0x20. For a read, running out ends the request with err=1 and no further access.
- R9: For a write, running out of start-bit polls sets err=1, but the status loop still runs.
- R10: The status loop makes at most 60 reads of 0x70. Running out gives err=1, and a read then makes no fetch of 0x08.
- R11: After a clean read, rdata equals the low byte of the swapped message-buffer word.
- R12: A poll access is granted no sooner than poll_gap+1 cycles after the previous access.
- R13: A request with req_mode 2'b10 or 2'b11 gives done=1 and err=1 in the cycle after acceptance, and makes no bus access.
- R14: After reset and between requests, req_ready=1 and the bus is idle. While a request runs, req_ready=0, further request pulses are ignored, and done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request strobe, taken when req_ready is high |
| req_ready | output | 1 | idle, able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 addressed, 01 direct, others unsupported |
| req_dev | input | 8 | device address byte, bits 7:1 used |
| req_index | input | 8 | register index inside the controller |
| req_wdata | input | 8 | byte to write |
| poll_gap | input | GAP_W | cycles waited before each poll |
| done | output | 1 | one-cycle completion pulse |
| err | output | 1 | error flag of the last request |
| rdata | output | 8 | byte returned by the last clean read |
| bus_valid | output | 1 | access request on the host bus |
| bus_ready | input | 1 | access accepted, read data valid |
| bus_we | output | 1 | 1 = write access |
| bus_addr | output | AW | byte offset of the access |
| bus_wdata | output | 32 | write word, byte-swapped |
| bus_rdata | input | 32 | read word, byte-swapped |

## Verification
The bench targets four groups of corner cases:
- the loop limits, using 59 failed start polls (which must still pass) and runs that overrun the start and status limits;
- the asymmetry between a read and a write after a start timeout;
- status words whose set bits all lie outside the completion mask;
- request strobes that arrive while the block is busy.

A design with an off-by-one loop counter would issue 61 reads or fail a request on its 60th read. If a read did not abort after a start timeout, extra status polls would appear. A mask error would hang in the status loop until timeout. Ignoring the busy state would start a second, unexpected access script. Varying bus latency and a zero poll gap expose any access that does not hold until ready, or any poll that starts early.

// File: rtl/hp_seq_pkg.sv
package hp_seq_pkg;

    // request addressing modes
    localparam logic [1:0] MODE_ADDR   = 2'b00;
    localparam logic [1:0] MODE_DIRECT = 2'b01;

    // register offsets of the I2C master
    localparam int OFS_MBUF      = 'h08;
    localparam int OFS_SETUP     = 'h10;
    localparam int OFS_CTRL      = 'h20;
    localparam int OFS_STAT      = 'h70;
    localparam int OFS_SET_ALIAS = 'h2000;

    // setup word bases
    localparam logic [31:0] SETUP_AT_RD  = 32'h0001_0000;
    localparam logic [31:0] SETUP_AT_WR  = 32'h4001_0000;
    localparam logic [31:0] SETUP_DIR_RD = 32'h1001_0000;
    localparam logic [31:0] SETUP_DIR_WR = 32'h6001_0000;

    localparam logic [31:0] CTRL_START     = 32'h0000_0002;
    localparam logic [31:0] STAT_BUSY_MASK = 32'h0000_0A76;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_MBUF,
        S_START,
        S_GAP_CTRL,
        S_POLL_CTRL,
        S_GAP_STAT,
        S_POLL_STAT,
        S_FETCH,
        S_DONE
    } seq_state_e;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/hp_seq_word.sv
module hp_seq_word
    import hp_seq_pkg::*;
(
    input  logic        is_write,
    input  logic        is_direct,
    input  logic [6:0]  dev_hi,
    input  logic [7:0]  index,
    input  logic [7:0]  wbyte,
    output logic [31:0] setup_word,
    output logic [31:0] mbuf_word
);

    always_comb begin
        if (is_direct) begin
            setup_word = (is_write ? SETUP_DIR_WR : SETUP_DIR_RD) | {16'h0, index, 8'h00};
        end else begin
            setup_word = (is_write ? SETUP_AT_WR : SETUP_AT_RD) | {16'h0, 1'b0, dev_hi, index};
        end
        mbuf_word = is_write ? {24'h0, wbyte} : 32'h0;
    end

endmodule

// File: rtl/hp_seq_pace.sv
module hp_seq_pace #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);

    logic [GAP_W-1:0] cnt;
    logic             reached;

    assign reached = (cnt >= gap);
    assign expired = run && reached;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!reached) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hp_i2c_seq.sv
module hp_i2c_seq
    import hp_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_POLLS = 60,
    parameter int GAP_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [1:0]       req_mode,
    input  logic [7:0]       req_dev,
    input  logic [7:0]       req_index,
    input  logic [7:0]       req_wdata,
    input  logic [GAP_W-1:0] poll_gap,
    output logic             done,
    output logic             err,
    output logic [7:0]       rdata,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [31:0]      bus_wdata,
    input  logic [31:0]      bus_rdata
);

    localparam int TW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] LAST_TRY = TW'(MAX_POLLS - 1);

    seq_state_e state, nxt;

    logic [31:0]   setup_w, mbuf_w, setup_q, mbuf_q, rd_word;
    logic          write_q, err_q;
    logic [7:0]    rdata_q;
    logic [TW-1:0] tries;
    logic          accept, mode_ok, last_try, ctrl_clear, stat_clear;
    logic          in_gap, gap_done;

    assign accept     = (state == S_IDLE) && req_valid;
    assign mode_ok    = (req_mode == MODE_ADDR) || (req_mode == MODE_DIRECT);
    assign last_try   = (tries == LAST_TRY);
    assign rd_word    = swap32(bus_rdata);
    assign ctrl_clear = (rd_word & CTRL_START) == 32'h0;
    assign stat_clear = (rd_word & STAT_BUSY_MASK) == 32'h0;
    assign in_gap     = (state == S_GAP_CTRL) || (state == S_GAP_STAT);

    hp_seq_word u_word (
        .is_write   (req_write),
        .is_direct  (req_mode == MODE_DIRECT),
        .dev_hi     (req_dev[7:1]),
        .index      (req_index),
        .wbyte      (req_wdata),
        .setup_word (setup_w),
        .mbuf_word  (mbuf_w)
    );

    hp_seq_pace #(.GAP_W(GAP_W)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_gap),
        .gap     (poll_gap),
        .expired (gap_done)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (req_valid) nxt = mode_ok ? S_SETUP : S_DONE;
            S_SETUP:     if (bus_ready) nxt = S_MBUF;
            S_MBUF:      if (bus_ready) nxt = S_START;
            S_START:     if (bus_ready) nxt = S_GAP_CTRL;
            S_GAP_CTRL:  if (gap_done)  nxt = S_POLL_CTRL;
            S_POLL_CTRL: begin
                if (bus_ready) begin
                    if (ctrl_clear)    nxt = S_GAP_STAT;
                    else if (last_try) nxt = write_q ? S_GAP_STAT : S_DONE;
                    else               nxt = S_GAP_CTRL;
                end
            end
            S_GAP_STAT:  if (gap_done)  nxt = S_POLL_STAT;
            S_POLL_STAT: begin
                if (bus_ready) begin
                    if (stat_clear)    nxt = write_q ? S_DONE : S_FETCH;
                    else if (last_try) nxt = S_DONE;
                    else               nxt = S_GAP_STAT;
                end
            end
            S_FETCH:     if (bus_ready) nxt = S_DONE;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // request context, loop counter, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            setup_q <= '0;
            mbuf_q  <= '0;
            err_q   <= 1'b0;
            tries   <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            setup_q <= setup_w;
            mbuf_q  <= mbuf_w;
            err_q   <= !mode_ok;
            tries   <= '0;
        end else if (state == S_POLL_CTRL && bus_ready) begin
            if (ctrl_clear) begin
                tries <= '0;
            end else if (last_try) begin
                err_q <= 1'b1;
                tries <= '0;
            end else begin
                tries <= tries + 1'b1;
            end
        end else if (state == S_POLL_STAT && bus_ready) begin
            if (!stat_clear) begin
                if (last_try) err_q <= 1'b1;
                else          tries <= tries + 1'b1;
            end
        end else if (state == S_FETCH && bus_ready) begin
            rdata_q <= rd_word[7:0];
        end
    end

    // outputs
    always_comb begin
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            S_SETUP: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(OFS_SETUP);
                bus_wdata = swap32(setup_q);
            end
            S_MBUF: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(OFS_MBUF);
                bus_wdata = swap32(mbuf_q);
            end
            S_START: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(OFS_CTRL + OFS_SET_ALIAS);
                bus_wdata = swap32(CTRL_START);
            end
            S_POLL_CTRL: begin
                bus_valid = 1'b1;
                bus_addr  = AW'(OFS_CTRL);
            end
            S_POLL_STAT: begin
                bus_valid = 1'b1;
                bus_addr  = AW'(OFS_STAT);
            end
            S_FETCH: begin
                bus_valid = 1'b1;
                bus_addr  = AW'(OFS_MBUF);
            end
            default: ;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign done      = (state == S_DONE);
    assign err       = err_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/hp_i2c_seq_chk.sv
module hp_i2c_seq_chk #(
    parameter int AW        = 16,
    parameter int MAX_POLLS = 60
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_mode,
    input logic          done,
    input logic          err,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata
);

    int unsigned ctrl_reads;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                           ctrl_reads <= 0;
        else if (req_valid && req_ready)                      ctrl_reads <= 0;
        else if (bus_valid && bus_ready && !bus_we && bus_addr == AW'('h20)) ctrl_reads <= ctrl_reads + 1;
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R1

    AST_START_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_we && bus_addr == AW'('h2020) |-> bus_wdata == 32'h0200_0000); // R5

    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_mode[1] |=> done && err && !bus_valid); // R13

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R14

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_valid); // R14

    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reads <= MAX_POLLS); // R8

endmodule

bind hp_i2c_seq hp_i2c_seq_chk #(.AW(AW), .MAX_POLLS(MAX_POLLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .done      (done),
    .err       (err),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/hp_i2c_seq_tb_top.sv
`timescale 1ns/1ps
module hp_i2c_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [7:0]  req_dev = 8'h0;
    logic [7:0]  req_index = 8'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [15:0] poll_gap = 16'd3;
    logic        done, err;
    logic [7:0]  rdata;
    logic        bus_valid, bus_we;
    logic        bus_ready = 1'b0;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = 32'h0;

    always #4 clk = ~clk;

    hp_i2c_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mode(req_mode), .req_dev(req_dev),
        .req_index(req_index), .req_wdata(req_wdata), .poll_gap(poll_gap),
        .done(done), .err(err), .rdata(rdata), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // expected access script
    bit          q_we[$];
    logic [15:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_req[$];

    // register-file model of the I2C master
    int          s_start_left = 0;
    int          s_stat_left = 0;
    logic [31:0] s_busy = 32'h800;
    logic [7:0]  s_byte = 8'h0;
    int          s_lat = 0;
    int          wait_cnt = 0;
    int          stray = 0;
    int          last_grant = 0;

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit we, input logic [15:0] a, input logic [31:0] d, input string r);
        q_we.push_back(we);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_req.push_back(r);
    endtask

    task automatic serve();
        bit          ewe;
        logic [15:0] ea;
        logic [31:0] ed;
        string       er;
        if (q_we.size() == 0) begin
            stray++;
        end else begin
            ewe = q_we.pop_front();
            ea  = q_addr.pop_front();
            ed  = q_data.pop_front();
            er  = q_req.pop_front();
            chk(bus_we == ewe && bus_addr == ea, er, "access address/direction",
                {15'h0, bus_we, bus_addr}, {15'h0, ewe, ea});
            if (ewe) chk(bus_wdata == ed, er, "write word (R6 byte order)", bus_wdata, ed);
        end
        if (!bus_we && (bus_addr == 16'h20 || bus_addr == 16'h70))
            chk(cyc - last_grant >= int'(poll_gap) + 1, "R12", "poll spacing",
                32'(cyc - last_grant), 32'(poll_gap + 1));
        last_grant = cyc;
        if (!bus_we) begin
            if (bus_addr == 16'h20) begin
                if (s_start_left > 0) begin
                    bus_rdata <= rev(32'h0000_0102);
                    s_start_left--;
                end else begin
                    bus_rdata <= rev(32'h0000_0100);
                end
            end else if (bus_addr == 16'h70) begin
                if (s_stat_left > 0) begin
                    bus_rdata <= rev(s_busy);
                    s_stat_left--;
                end else begin
                    bus_rdata <= rev(32'h0000_0181);
                end
            end else begin
                bus_rdata <= rev({24'hA5C3E1, s_byte});
            end
        end
    endtask

    always @(negedge clk) begin
        if (bus_ready) begin
            bus_ready <= 1'b0;
        end else if (bus_valid) begin
            if (wait_cnt < s_lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                bus_ready <= 1'b1;
                serve();
            end
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic run(input bit wr, input logic [1:0] mode, input logic [7:0] dev,
                       input logic [7:0] idx, input logic [7:0] wd, input int sp, input int tp,
                       input logic [31:0] busyw, input logic [7:0] rb, input string tag,
                       input bit poke);
        logic [31:0] su;
        bit          sup, sto, tto, exp_err;
        int          t;
        sup     = (mode == 2'b00) || (mode == 2'b01);
        exp_err = !sup;
        if (sup) begin
            if (mode == 2'b01) su = (wr ? 32'h6001_0000 : 32'h1001_0000) | {16'h0, idx, 8'h0};
            else               su = (wr ? 32'h4001_0000 : 32'h0001_0000) | {16'h0, 1'b0, dev[7:1], idx};
            push(1'b1, 16'h10, rev(su), (mode == 2'b01) ? "R3" : "R2");
            push(1'b1, 16'h08, rev(wr ? {24'h0, wd} : 32'h0), "R4");
            push(1'b1, 16'h2020, 32'h0200_0000, "R5");
            sto = (sp >= 60);
            for (int i = 0; i < (sto ? 60 : sp + 1); i++) push(1'b0, 16'h20, 32'h0, "R8");
            exp_err = sto;
            if (!sto || wr) begin
                tto = (tp >= 60);
                for (int i = 0; i < (tto ? 60 : tp + 1); i++) push(1'b0, 16'h70, 32'h0, "R7");
                exp_err = exp_err || tto;
                if (!wr && !tto) push(1'b0, 16'h08, 32'h0, "R1");
            end
        end
        s_start_left = sp;
        s_stat_left  = tp;
        s_busy       = busyw;
        s_byte       = rb;
        stray        = 0;
        @(negedge clk);
        req_write = wr; req_mode = mode; req_dev = dev; req_index = idx; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!sup) begin
            chk(done && err && !bus_valid, "R13", "unsupported mode completes at once",
                {29'h0, done, err, bus_valid}, 32'h6);
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(!req_ready, "R14", "ready low while busy", {31'h0, req_ready}, 32'h0);
            req_index = 8'h77;
            req_valid = 1'b1;
            repeat (5) @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done, tag, "request completed", {31'h0, done}, 32'h1);
        chk(err == exp_err, tag, "error flag", {31'h0, err}, {31'h0, exp_err});
        if (sup && !wr && !exp_err) chk(rdata == rb, "R11", "read byte", {24'h0, rdata}, {24'h0, rb});
        chk(q_we.size() == 0 && stray == 0, tag, "script length (R1)",
            32'(q_we.size() + stray), 32'h0);
        @(negedge clk);
        chk(!done && req_ready, "R14", "done single pulse",
            {30'h0, done, req_ready}, 32'h1);
        if (poke) begin
            repeat (12) @(negedge clk);
            chk(stray == 0 && !bus_valid, "R14", "busy-time request ignored",
                32'(stray), 32'h0);
        end
        q_we.delete(); q_addr.delete(); q_data.delete(); q_req.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !err && !bus_valid, "R14", "reset state",
            {28'h0, req_ready, done, err, bus_valid}, 32'h8);

        s_lat = 0;
        run(1'b0, 2'b00, 8'hA6, 8'h05, 8'h00, 2, 1, 32'h800, 8'h5A, "R2", 1'b0);
        s_lat = 1;
        run(1'b1, 2'b00, 8'h3F, 8'h11, 8'h3C, 0, 2, 32'h004, 8'h00, "R2", 1'b0);
        s_lat = 2;
        run(1'b0, 2'b01, 8'h00, 8'h28, 8'h00, 1, 0, 32'h800, 8'hC7, "R3", 1'b0);
        s_lat = 0;
        run(1'b1, 2'b01, 8'h50, 8'h0F, 8'h81, 3, 3, 32'h040, 8'h00, "R3", 1'b0);
        run(1'b0, 2'b10, 8'h50, 8'h0F, 8'h00, 0, 0, 32'h040, 8'h00, "R13", 1'b0);
        run(1'b1, 2'b11, 8'h50, 8'h0F, 8'h00, 0, 0, 32'h040, 8'h00, "R13", 1'b0);
        run(1'b0, 2'b00, 8'h42, 8'h01, 8'h00, 70, 0, 32'h800, 8'h11, "R8", 1'b0);
        run(1'b1, 2'b00, 8'h42, 8'h02, 8'h99, 70, 1, 32'h800, 8'h00, "R9", 1'b0);
        s_lat = 1;
        run(1'b0, 2'b01, 8'h00, 8'h1F, 8'h00, 0, 65, 32'h200, 8'h22, "R10", 1'b0);
        run(1'b0, 2'b00, 8'h42, 8'h03, 8'h00, 59, 59, 32'h010, 8'h6E, "R8", 1'b0);
        s_lat = 0;
        run(1'b0, 2'b00, 8'h42, 8'h04, 8'h00, 0, 4, 32'h020, 8'hB4, "R7", 1'b0);
        poll_gap = 16'd0;
        run(1'b0, 2'b01, 8'h00, 8'h25, 8'h00, 3, 2, 32'h002, 8'h3D, "R12", 1'b0);
        poll_gap = 16'd3;
        run(1'b1, 2'b00, 8'h84, 8'h06, 8'h5F, 8, 2, 32'h800, 8'h00, "R14", 1'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule